// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block sits at the output of a clock generator and gates one group of derived clocks, such as a processor clock group or a peripheral-bus clock group. A single active-low stop request arrives with no timing relation to the group clock. The block synchronizes it to the group clock and then stops or restarts the gated outputs. A stopped output always parks at logic 0. Each gate decision is registered on the falling edge of the clock, so the gate can only open or close while the clock is low. Every high phase that reaches an output is therefore a whole one.

Each output has two control bits, both supplied from configuration registers elsewhere. The enable bit forces the output off when it is 0. The free-run bit, when 1, exempts the output from the stop request, so that output keeps toggling while the rest of the group is halted. Clock synthesis is outside this block: it receives the already divided group clock.

A two-state controller decides whether the group runs. In `ST_RUN`, gated outputs follow the clock. When the synchronized request is low, the controller takes the transition **halt** to `ST_HALT`. In `ST_HALT`, outputs without the free-run bit rest low. When the synchronized request returns high, the controller takes the transition **resume** back to `ST_RUN`. Reset places the controller in `ST_RUN`.

Top module: `clk_stop_gate`

## Requirements
- R1: The stop request passes through a SYNC_STAGES-flop synchronizer and the controller register before it acts. Take rising edge 0 as the first edge that samples the request low. A stoppable output then delivers exactly SYNC_STAGES+1 more high pulses (3 with the defaults, fewer than 4), on rising edges 0 to 2, and none afterwards.
- R2: The internal gate of each output changes only while the source clock is low. An output's level therefore never changes during a high phase of the source clock, including when the masks change during that phase. While the source clock is low, every output is low.
- R3: In `ST_RUN`, a low synchronized request causes the halt transition to `ST_HALT` on the next rising edge.
- R4: In `ST_HALT`, a high synchronized request causes the resume transition to `ST_RUN`. Take rising edge 0 as the first edge that samples the request high. A stopped output stays low on rising edges 0 to SYNC_STAGES and gives its first full high pulse on rising edge SYNC_STAGES+1 (edge 3 with the defaults).
- R5: An output whose free-run bit (`free_run_i[i]`) is 1 and whose enable bit is 1 toggles in every cycle, whatever the stop request does.
- R6: An output whose enable bit (`out_en_i[i]`) is 0 stays low, whatever the stop request and its free-run bit are.
- R7: While the group is halted, free-running enabled outputs keep toggling with no missing or extra pulse. At the same time, the stoppable outputs stay low.
- R8: While `rst_ni` is low, every output is low and the controller is in `ST_RUN`. The synchronizer holds the not-stopped value.
- R9: Bit i of each mask controls output i. A mask value present at a falling edge of the source clock governs the high phase that starts at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock of the group |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_ni | input | 1 | Asynchronous active-low stop request |
| out_en_i | input | N_OUT | Per-output enable, 0 holds the output low |
| free_run_i | input | N_OUT | Per-output free-run bit, 1 ignores the stop request |
| clk_o | output | N_OUT | Gated clock outputs |

## Verification
The bench builds the block with N_OUT = 7 and SYNC_STAGES = 2. Seven outputs leave room for masks that mix free-running, stoppable and disabled outputs in the same cycle, so that R7 can be observed while other outputs are halted. Two stages fix both the stop and restart latency at exactly three rising edges. That makes exact pulse counts possible across a stop and a restart. Random request runs, including the shortest legal release pulses, are applied while the masks change between rising and falling edges.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } gate_state_e;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_ni,
    output logic sync_no
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    // Chain resets to the not-stopped value (R8).
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[TOP-1:0], async_ni};
        end
    end

    assign sync_no = chain_q[TOP];

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_ni,
    output logic run_o
);
    gate_state_e state_q;
    gate_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (!req_ni) state_d = ST_HALT;   // halt
            ST_HALT: if (req_ni)  state_d = ST_RUN;    // resume
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  run_o = 1'b1;
            ST_HALT: run_o = 1'b0;
            default: run_o = 1'b1;
        endcase
    end

    assert_halt_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && !req_ni) |=> (state_q == ST_HALT));

    assert_resume_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HALT && req_ni) |=> (state_q == ST_RUN));

endmodule

// File: rtl/clkstop_gate_cell.sv
module clkstop_gate_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic en_i,
    input  logic frun_i,
    output logic clk_o
);
    logic gate_q;

    // Falling-edge register: the gate moves only while clk_i is low.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= en_i & (frun_i | run_i);
        end
    end

    assign clk_o = clk_i & gate_q;

    always @(posedge gate_q or negedge gate_q) begin
        if (rst_ni) begin
            assert_edge_low_R2: assert (!clk_i)
                else $error("gate moved while clock high");
        end
    end

    assert_disabled_low_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
        !en_i |=> !gate_q);

    assert_free_run_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (en_i && frun_i) |=> gate_q);

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int N_OUT       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_req_ni,
    input  logic [N_OUT-1:0] out_en_i,
    input  logic [N_OUT-1:0] free_run_i,
    output logic [N_OUT-1:0] clk_o
);
    logic req_sync_n;
    logic run;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .async_ni (stop_req_ni),
        .sync_no  (req_sync_n)
    );

    clkstop_ctrl u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_ni (req_sync_n),
        .run_o  (run)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        clkstop_gate_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .run_i  (run),
            .en_i   (out_en_i[i]),
            .frun_i (free_run_i[i]),
            .clk_o  (clk_o[i])
        );
    end

endmodule

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/100ps
module sim_clk_stop_gate;
    localparam int N = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_n = 1'b1;
    logic [N-1:0] en = '1;
    logic [N-1:0] frun = '0;
    logic [N-1:0] cko;

    always #2 clk = ~clk;

    clk_stop_gate #(.N_OUT(N), .SYNC_STAGES(2)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .stop_req_ni(stop_n),
        .out_en_i(en), .free_run_i(frun), .clk_o(cko)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic s1 = 1'b1, s2 = 1'b1, stm = 1'b1, stm_at = 1'b1;
    logic [N-1:0] exp_v = '0, en_at = '0, fr_at = '0;
    string force_tag = "";

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: clk_o actual=%b expected=%b at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic string pick_tag(input logic [N-1:0] diff);
        if (force_tag != "") return force_tag;
        if ((diff & ~en_at) != '0) return "R6";
        if ((diff & fr_at) != '0) return "R5";
        return stm_at ? "R4" : "R1";
    endfunction

    // One source-clock cycle: check high phase, drive, check stability and low phase.
    task automatic step(input logic stop_v, input logic [N-1:0] en_v,
                        input logic [N-1:0] fr_v, output logic [N-1:0] hi);
        @(posedge clk);
        #0.5;
        hi = cko;
        chk(pick_tag(hi ^ exp_v), hi, exp_v);
        stm = s2; s2 = s1; s1 = stop_n;
        #0.5;
        stop_n = stop_v; en = en_v; frun = fr_v;
        #0.5;
        chk("R2", cko, hi);
        #1.0;
        chk("R2", cko, '0);
        exp_v = en & (frun | {N{stm}});
        en_at = en; fr_at = frun; stm_at = stm;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1: run incomplete actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] hi;
        int cnt;
        int first;
        logic [N-1:0] e_r, f_r;
        logic st_r;
        void'($urandom(32'd20240611));

        // R8: reset holds outputs low
        repeat (3) @(posedge clk);
        #0.5;
        chk("R8", cko, '0);
        #0.5;
        rst_n = 1'b1;
        exp_v = en & (frun | {N{stm}});
        en_at = en; fr_at = frun; stm_at = 1'b1;

        repeat (5) step(1'b1, '1, '0, hi);

        // R1: exactly 3 more pulses after the request is sampled low
        step(1'b0, '1, '0, hi);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            step(1'b0, '1, '0, hi);
            if (hi[0]) cnt++;
        end
        chk("R1", N'(cnt), N'(3));

        // R4: first pulse on the fourth rising edge after release
        step(1'b1, '1, '0, hi);
        first = -1;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, '1, '0, hi);
            if (hi[0] && first < 0) first = k;
        end
        chk("R4", N'(first), N'(3));

        // R5 and R7: free-running outputs continue through a halt
        force_tag = "R7";
        for (int k = 0; k < 20; k++) step(1'b0, '1, 7'b0100101, hi);
        for (int k = 0; k < 12; k++) step(1'b1, '1, 7'b0100101, hi);
        force_tag = "R5";
        for (int k = 0; k < 8; k++) step(k[0], '1, '1, hi);

        // R6: disabled outputs stay low even when free-running
        force_tag = "R6";
        for (int k = 0; k < 12; k++) step(1'b1, 7'b1010101, 7'b0101010, hi);

        // R9: mask toggled every cycle takes effect one edge later
        force_tag = "R9";
        for (int k = 0; k < 12; k++) step(1'b1, N'(1 << (k % N)), '0, hi);
        force_tag = "";
        for (int k = 0; k < 12; k++) step(1'b1, '1, '0, hi);

        // Random runs, with release pulses of at least 10 cycles
        e_r = '1; f_r = '0; st_r = 1'b1;
        for (int run = 0; run < 160; run++) begin
            int len;
            st_r = ~st_r;
            len = st_r ? 10 + int'($urandom_range(0, 30)) : 1 + int'($urandom_range(0, 25));
            for (int k = 0; k < len; k++) begin
                if ($urandom_range(0, 7) == 0) e_r = N'($urandom);
                if ($urandom_range(0, 7) == 0) f_r = N'($urandom);
                step(st_r, e_r, f_r, hi);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule